// File: doc/BRIEF.md
# Inter-Task Register Reservation Unit

This unit keeps register dependences in order between speculative tasks that run on a ring of processing elements (PEs). Tasks are handed to PEs in ring order, starting after the youngest active task, and leave the ring in the same order from the head. Each PE holds a local copy of the architectural registers and a reservation vector with one bit per register. A set bit means an older task may still produce the value, so a read of that register must stall.

When a task starts, each task header supplies the mask of registers it might write. The new task's reservations become the OR of the still-outstanding create bits of every older active task, and its local copy is loaded from the PE just before it in the ring. A write with its forward flag set, an explicit release, or the end of a task (which releases every outstanding register at once) puts the value on the ring. Younger tasks take the value in age order, clearing their reservation, and the value stops after the first younger task that itself creates that register. A squash puts a speculative task's reservations and copy back to their state at task start. Register 0 is hard-wired to zero and is never reserved.

Top module: `ring_resv_unit`

## Requirements
- R1: After reset no PE is active, the head index is 0, every register copy reads zero and no register is reserved.
- R2: A start (op code 1) activates the PE after the youngest active task, or the head PE when the ring is empty. Its reservations equal the OR of the outstanding create bits of all older active tasks, and its copy is loaded from the preceding PE. A start is ignored while all PEs are active.
- R3: The read port returns the selected PE's local copy of the selected register, and raises stall exactly when that PE's reservation bit for the register is set.
- R4: Register 0 is never reserved, always reads zero, and is never written. Create-mask bit 0 is discarded.
- R5: A write (op code 2) to an active PE updates that PE's copy and clears its own reservation for the register. It sends the value on only when the forward flag is 1 and the register is still outstanding in the writer's create mask, and that outstanding bit is then cleared.
- R6: A sent value visits the younger active tasks in age order. Each one that still holds the reservation clears it and stores the value. The value stops after the first younger task whose create mask has the register, and it never wraps past the youngest task.
- R7: A release (op code 3) of an outstanding register sends the PE's current copy of it and clears the outstanding bit. A release of a register that is not outstanding has no effect.
- R8: A stop (op code 4) sends every register still outstanding for that PE in the same cycle and marks the task finished.
- R9: A squash (op code 5) of an active non-head PE restores its outstanding bits to its create mask, sets its reservations to the OR of the outstanding bits of the older active tasks, clears its finished state, and reloads its copy from the preceding PE. A squash of the head has no effect.
- R10: A retire (op code 6) frees the head PE and advances the head index by one, modulo the ring size, but only when the head task has finished. Otherwise nothing changes, and the head index changes at no other time.
- R11: Writes, releases, stops and squashes aimed at an inactive PE change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_kind | input | 3 | Operation: 0 none, 1 start, 2 write, 3 release, 4 stop, 5 squash, 6 retire |
| op_pe | input | log2(NPE) | Target PE (not used by start or retire) |
| op_reg | input | log2(NREG) | Register number for write and release |
| op_data | input | W | Write data |
| op_fwd | input | 1 | Forward flag of the writing instruction |
| op_mask | input | NREG | Create mask for start |
| rd_pe | input | log2(NPE) | PE selected by the read port |
| rd_reg | input | log2(NREG) | Register selected by the read port |
| rd_data | output | W | Local copy of the selected register |
| rd_stall | output | 1 | Selected register is still reserved |
| task_active | output | NPE | One bit per PE holding a task |
| head_pe | output | log2(NPE) | Index of the oldest active task |

## Verification
The hardest case to reach is a value that travels around the ring and meets a younger task that creates the same register, or that no longer holds the reservation because it wrote the register itself or was squashed. Reaching it takes a full ring whose create masks overlap, with writes, releases and squashes spread across PEs of different age. The bench first builds that situation on purpose with a fixed sequence on a full ring. It then runs a long phase of weighted random operations with sparse, overlapping masks. In both phases a queue-based behavioural model is compared against the read port, the active vector and the head index on every clock.

// File: rtl/ring_resv_unit.sv
module ring_resv_unit #(
  parameter int NPE  = 4,
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int PW  = $clog2(NPE),
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      op_kind,
  input  logic [PW-1:0]   op_pe,
  input  logic [RW-1:0]   op_reg,
  input  logic [W-1:0]    op_data,
  input  logic            op_fwd,
  input  logic [NREG-1:0] op_mask,
  input  logic [PW-1:0]   rd_pe,
  input  logic [RW-1:0]   rd_reg,
  output logic [W-1:0]    rd_data,
  output logic            rd_stall,
  output logic [NPE-1:0]  task_active,
  output logic [PW-1:0]   head_pe
);
  localparam logic [2:0] K_START = 3'd1, K_WRITE = 3'd2, K_REL = 3'd3,
                         K_STOP = 3'd4, K_SQUASH = 3'd5, K_RETIRE = 3'd6;

  logic [NPE-1:0]  act, stp;
  logic [PW-1:0]   head, tail, ap, apred;
  logic [NREG-1:0] cre [NPE];
  logic [NREG-1:0] pend [NPE];
  logic [NREG-1:0] resv [NPE];
  logic [NREG-1:0] recv [NPE];
  logic [W-1:0]    rf [NPE][NREG];
  logic [W-1:0]    sd [NREG];
  logic [NREG-1:0] sv, acc, newmask;
  logic            full, tgt;

  assign full    = &act;
  assign tail    = head + PW'($countones(act));
  assign tgt     = act[op_pe];
  assign ap      = (op_kind == K_START) ? tail : op_pe;
  assign apred   = ap - PW'(1);
  assign newmask = op_mask & ~NREG'(1);

  assign rd_data     = rf[rd_pe][rd_reg];
  assign rd_stall    = resv[rd_pe][rd_reg];
  assign task_active = act;
  assign head_pe     = head;

  always_comb begin
    logic [PW-1:0] qi;
    acc = '0;
    for (int q = 0; q < NPE; q++) begin
      qi = PW'(q);
      if (act[q] && (PW'(qi - head) < PW'(ap - head))) acc |= pend[q];
    end
  end

  always_comb begin
    sv = '0;
    for (int r = 0; r < NREG; r++) sd[r] = rf[op_pe][r];
    if (tgt) begin
      case (op_kind)
        K_WRITE: if (op_reg != '0 && op_fwd && pend[op_pe][op_reg]) begin
          sv[op_reg] = 1'b1;
          sd[op_reg] = op_data;
        end
        K_REL:  sv[op_reg] = pend[op_pe][op_reg];
        K_STOP: sv = pend[op_pe];
        default: ;
      endcase
    end
  end

  always_comb begin
    logic          pass;
    logic [PW-1:0] q;
    for (int p = 0; p < NPE; p++) recv[p] = '0;
    for (int r = 0; r < NREG; r++) begin
      pass = sv[r];
      for (int d = 1; d < NPE; d++) begin
        q = op_pe + PW'(d);
        if (q == head || !act[q]) pass = 1'b0;
        if (pass) recv[q][r] = 1'b1;
        if (cre[q][r]) pass = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= '0;
      stp  <= '0;
      head <= '0;
      for (int p = 0; p < NPE; p++) begin
        cre[p]  <= '0;
        pend[p] <= '0;
        resv[p] <= '0;
        for (int r = 0; r < NREG; r++) rf[p][r] <= '0;
      end
    end else begin
      for (int p = 0; p < NPE; p++)
        for (int r = 0; r < NREG; r++)
          if (recv[p][r] && resv[p][r]) begin
            resv[p][r] <= 1'b0;
            rf[p][r]   <= sd[r];
          end
      case (op_kind)
        K_START: if (!full) begin
          act[tail]  <= 1'b1;
          stp[tail]  <= 1'b0;
          cre[tail]  <= newmask;
          pend[tail] <= newmask;
          resv[tail] <= acc;
          for (int r = 0; r < NREG; r++) rf[tail][r] <= rf[apred][r];
        end
        K_WRITE: if (tgt && op_reg != '0) begin
          rf[op_pe][op_reg]   <= op_data;
          resv[op_pe][op_reg] <= 1'b0;
          if (op_fwd) pend[op_pe][op_reg] <= 1'b0;
        end
        K_REL: if (tgt) pend[op_pe][op_reg] <= 1'b0;
        K_STOP: if (tgt) begin
          pend[op_pe] <= '0;
          stp[op_pe]  <= 1'b1;
        end
        K_SQUASH: if (tgt && op_pe != head) begin
          pend[op_pe] <= cre[op_pe];
          resv[op_pe] <= acc;
          stp[op_pe]  <= 1'b0;
          for (int r = 0; r < NREG; r++) rf[op_pe][r] <= rf[apred][r];
        end
        K_RETIRE: if (act[head] && stp[head]) begin
          act[head] <= 1'b0;
          head      <= head + PW'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ring_resv_chk.sv
module ring_resv_chk #(
  parameter int NPE  = 4,
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int PW  = $clog2(NPE),
  localparam int RW  = $clog2(NREG)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2:0]     op_kind,
  input logic [RW-1:0]  rd_reg,
  input logic [W-1:0]   rd_data,
  input logic           rd_stall,
  input logic [NPE-1:0] task_active,
  input logic [PW-1:0]  head_pe
);
  a_r4_zero_free: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_reg == '0) |-> (!rd_stall && rd_data == '0));

  a_r2_start_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == 3'd1 && !(&task_active)) |=>
      ($countones(task_active) == $past($countones(task_active)) + 1));

  a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == 3'd1 && (&task_active)) |=> $stable(task_active));

  a_r9_squash_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == 3'd5) |=> ($stable(task_active) && $stable(head_pe)));

  a_r10_head_only_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind != 3'd6) |=> $stable(head_pe));
endmodule

bind ring_resv_unit ring_resv_chk #(.NPE(NPE), .NREG(NREG), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .rd_reg(rd_reg),
  .rd_data(rd_data), .rd_stall(rd_stall), .task_active(task_active),
  .head_pe(head_pe));

// File: tb/tb_ring_resv_unit.sv
`timescale 1ns/1ps
module tb_ring_resv_unit;
  localparam int NPE = 4, NREG = 32, W = 32;
  localparam logic [2:0] NOP = 0, START = 1, WRITE = 2, REL = 3, STOP = 4,
                         SQUASH = 5, RETIRE = 6;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic [2:0] op_kind = 0; logic [1:0] op_pe = 0; logic [4:0] op_reg = 0;
  logic [31:0] op_data = 0; logic op_fwd = 0; logic [31:0] op_mask = 0;
  logic [1:0] rd_pe = 0; logic [4:0] rd_reg = 0;
  wire [31:0] rd_data; wire rd_stall; wire [3:0] task_active; wire [1:0] head_pe;

  ring_resv_unit #(.NPE(NPE), .NREG(NREG), .W(W)) dut (.*);

  int checks = 0, fails = 0;
  bit [31:0] m_cre [4], m_pend [4], m_resv [4];
  bit m_stp [4];
  logic [31:0] m_rf [4][32];
  int ord [$];
  int m_head = 0;
  logic s_stall; logic [31:0] s_data;

  task automatic chk(bit ok, string tag, logic [63:0] a, logic [63:0] e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  function automatic int pos(int p);
    foreach (ord[i]) if (ord[i] == p) return i;
    return -1;
  endfunction

  function automatic logic [3:0] act_vec();
    logic [3:0] v = 0;
    foreach (ord[i]) v[ord[i]] = 1'b1;
    return v;
  endfunction

  task automatic send(int s, int r, logic [31:0] v);
    int i = pos(s);
    for (int j = i + 1; j < ord.size(); j++) begin
      int q = ord[j];
      if (m_resv[q][r]) begin m_resv[q][r] = 0; m_rf[q][r] = v; end
      if (m_cre[q][r]) break;
    end
  endtask

  task automatic model(logic [2:0] k, int pe, int rg, logic [31:0] d, bit f, logic [31:0] m);
    bit [31:0] acc = 0;
    int t, i;
    bit on = (pos(pe) >= 0);
    case (k)
      START: if (ord.size() < NPE) begin
        t = (m_head + ord.size()) % NPE;
        foreach (ord[j]) acc |= m_pend[ord[j]];
        for (int r = 0; r < NREG; r++) m_rf[t][r] = m_rf[(t + NPE - 1) % NPE][r];
        m_cre[t] = m & ~32'd1; m_pend[t] = m & ~32'd1; m_resv[t] = acc; m_stp[t] = 0;
        ord.push_back(t);
      end
      WRITE: if (on && rg != 0) begin
        m_rf[pe][rg] = d; m_resv[pe][rg] = 0;
        if (f && m_pend[pe][rg]) begin m_pend[pe][rg] = 0; send(pe, rg, d); end
      end
      REL: if (on && m_pend[pe][rg]) begin m_pend[pe][rg] = 0; send(pe, rg, m_rf[pe][rg]); end
      STOP: if (on) begin
        for (int r = 0; r < NREG; r++) if (m_pend[pe][r]) send(pe, r, m_rf[pe][r]);
        m_pend[pe] = 0; m_stp[pe] = 1;
      end
      SQUASH: if (on && pe != ord[0]) begin
        i = pos(pe);
        for (int j = 0; j < i; j++) acc |= m_pend[ord[j]];
        m_resv[pe] = acc; m_pend[pe] = m_cre[pe]; m_stp[pe] = 0;
        for (int r = 0; r < NREG; r++) m_rf[pe][r] = m_rf[ord[i-1]][r];
      end
      RETIRE: if (ord.size() > 0 && m_stp[ord[0]]) begin
        void'(ord.pop_front()); m_head = (m_head + 1) % NPE;
      end
      default: ;
    endcase
  endtask

  task automatic step(logic [2:0] k, int pe, int rg, logic [31:0] d, bit f,
                      logic [31:0] m, int rp, int rr);
    op_kind = k; op_pe = 2'(pe); op_reg = 5'(rg); op_data = d; op_fwd = f; op_mask = m;
    rd_pe = 2'(rp); rd_reg = 5'(rr);
    #1;
    s_stall = rd_stall; s_data = rd_data;
    chk(rd_stall === m_resv[rp][rr], "R3 stall vs model", rd_stall, m_resv[rp][rr]);
    chk(rd_data === m_rf[rp][rr], "R3 data vs model", rd_data, m_rf[rp][rr]);
    chk(task_active === act_vec(), "R2 active vector vs model", task_active, act_vec());
    chk(head_pe === 2'(m_head), "R10 head vs model", head_pe, m_head);
    @(posedge clk);
    model(k, pe, rg, d, f, m);
    @(negedge clk);
  endtask

  task automatic peek(int rp, int rr, bit es, logic [31:0] ed, string tag);
    step(NOP, 0, 0, 0, 0, 0, rp, rr);
    chk(s_stall === es, {tag, " stall"}, s_stall, es);
    chk(s_data === ed, {tag, " data"}, s_data, ed);
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired, run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int p = 0; p < NPE; p++) begin
      m_cre[p] = 0; m_pend[p] = 0; m_resv[p] = 0; m_stp[p] = 0;
      for (int r = 0; r < NREG; r++) m_rf[p][r] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    for (int p = 0; p < NPE; p++)
      for (int r = 0; r < NREG; r++) peek(p, r, 0, 0, "R1 reset state");

    step(START, 0, 0, 0, 0, 32'h27, 0, 0);
    step(START, 0, 0, 0, 0, 32'h0C, 0, 0);
    step(START, 0, 0, 0, 0, 32'h80, 0, 0);
    step(START, 0, 0, 0, 0, 32'h00, 0, 0);
    step(START, 0, 0, 0, 0, 32'h200, 0, 0);
    chk(task_active === 4'hF, "R2 full ring ignores start", task_active, 4'hF);
    peek(1, 1, 1, 0, "R2 reserved from older create");
    peek(3, 7, 1, 0, "R2 reserved from older create");
    peek(0, 1, 0, 0, "R2 head has no reservation");
    peek(1, 0, 0, 0, "R4 zero never reserved");

    step(WRITE, 0, 1, 32'h11, 1, 0, 0, 0);
    peek(3, 1, 0, 32'h11, "R6 value reaches youngest");
    peek(0, 1, 0, 32'h11, "R5 own copy written");
    step(WRITE, 0, 2, 32'h22, 1, 0, 0, 0);
    peek(1, 2, 0, 32'h22, "R6 creator takes value");
    peek(2, 2, 1, 0, "R6 stops after creator");
    step(WRITE, 0, 5, 32'h55, 0, 0, 0, 0);
    peek(1, 5, 1, 0, "R5 no send without forward flag");
    step(WRITE, 0, 0, 32'hDEAD, 1, 0, 0, 0);
    peek(0, 0, 0, 0, "R4 zero not written");
    step(RETIRE, 0, 0, 0, 0, 0, 0, 0);
    chk(head_pe === 2'd0, "R10 unfinished head kept", head_pe, 0);
    step(STOP, 0, 0, 0, 0, 0, 0, 0);
    peek(3, 5, 0, 32'h55, "R8 stop releases pending");
    peek(2, 5, 0, 32'h55, "R8 stop releases pending");
    peek(2, 3, 1, 0, "R7 before release");
    step(REL, 1, 3, 0, 0, 0, 0, 0);
    peek(3, 3, 0, 0, "R7 release clears younger");
    step(WRITE, 1, 3, 32'h33, 1, 0, 0, 0);
    peek(2, 3, 0, 0, "R5 released register not sent again");
    step(RETIRE, 1, 0, 0, 0, 0, 0, 0);
    chk(head_pe === 2'd1, "R10 head advances", head_pe, 1);
    chk(task_active === 4'b1110, "R10 head freed", task_active, 4'b1110);
    step(WRITE, 2, 2, 32'h99, 0, 0, 0, 0);
    peek(2, 2, 0, 32'h99, "R5 own write clears reservation");
    step(SQUASH, 2, 0, 0, 0, 0, 0, 0);
    peek(2, 2, 1, 32'h22, "R9 squash restores reservation and copy");
    peek(2, 1, 0, 32'h11, "R9 squash reloads copy");
    step(SQUASH, 1, 0, 0, 0, 0, 0, 0);
    step(WRITE, 0, 1, 32'hBEEF, 1, 0, 0, 0);
    peek(0, 1, 0, 32'h11, "R11 inactive PE untouched");
    step(START, 0, 0, 0, 0, 32'h2, 0, 0);
    peek(0, 1, 0, 32'h11, "R2 copy from preceding PE");
    peek(0, 7, 1, 0, "R2 reservation from older tasks");

    for (int n = 0; n < 6000; n++) begin
      int w = $urandom_range(0, 99);
      logic [2:0] k;
      if (w < 12) k = START; else if (w < 45) k = WRITE; else if (w < 55) k = REL;
      else if (w < 68) k = STOP; else if (w < 74) k = SQUASH; else if (w < 86) k = RETIRE;
      else k = NOP;
      step(k, $urandom_range(0, 3), $urandom_range(0, 31), $urandom, 1'($urandom_range(0, 1)),
           $urandom & $urandom & $urandom, $urandom_range(0, 3), $urandom_range(0, 31));
    end
    for (int p = 0; p < NPE; p++)
      for (int r = 0; r < NREG; r++) step(NOP, 0, 0, 0, 0, 0, p, r);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule